// File: doc/BRIEF.md
# Serial Flash Write Protection Unit

This block decides, for a 1 MiB serial flash split into sixteen 64 KiB sectors, whether a modifying command may execute. It keeps a write-enable latch, a three-bit protect code that marks an upper region of the array as read-only, and a status-lock bit. Together with the write-protect pin, the status-lock bit freezes the status register.

The command shifter raises `cmd_valid` for one cycle when chip select rises. With it come the decoded operation, the target address, the data byte for a status write, and the number of serial clock pulses counted while chip select was low. One cycle later the block answers with a one-cycle `permit` or `reject` pulse for each page program, sector erase, bulk erase or status write. The array engine raises `op_done` when an operation finishes. The interface has no back-pressure: a request is accepted on every cycle that `cmd_valid` is high, and the requester has to keep requests at least one cycle apart.

Top module: `flash_wprot_unit`

## Requirements
- R1: Operation codes on `cmd_op` are 0 enable-write, 1 disable-write, 2 page program, 3 sector erase, 4 bulk erase, 5 status write, 6 read and 7 idle. After reset, `wel`, `bp`, `srwd`, `permit` and `reject` are all 0. An enable-write request sets `wel` from the following cycle.
- R2: A disable-write request or an `op_done` pulse clears `wel`. If an enable-write request and `op_done` fall in the same cycle, `wel` ends up set.
- R3: Page program, sector erase, bulk erase and status write are rejected while `wel` is 0.
- R4: The protect code `bp` makes the following sectors (address bits 19:16) read-only: 0 none, 1 sector 15, 2 sectors 14-15, 3 sectors 12-15, 4 sectors 8-15, and 5, 6 or 7 all sectors. A page program or sector erase whose sector is in that set is rejected.
- R5: A bulk erase is rejected whenever `bp` is nonzero.
- R6: A status write is rejected when `srwd` is 1 and `wp_n` is 0. It is not blocked by `wp_n` when `srwd` is 0, nor by `srwd` when `wp_n` is 1.
- R7: A modifying command is rejected unless `cmd_clks` is a nonzero multiple of eight.
- R8: `permit` or `reject` is high for exactly the one cycle after the request. A rejected request changes neither `wel`, `bp` nor `srwd`.
- R9: A permitted status write loads `bp` from `cmd_data[4:2]` and `srwd` from `cmd_data[7]`, visible from the following cycle. Nothing else changes these bits.
- R10: Enable-write, disable-write, read and idle requests raise neither `permit` nor `reject`. Read and idle leave `wel`, `bp` and `srwd` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | One-cycle request strobe at chip-select rise |
| cmd_op | input | 3 | Decoded operation code |
| cmd_addr | input | 20 | Target byte address |
| cmd_clks | input | 16 | Serial clock pulses seen during the command |
| cmd_data | input | 8 | Byte for a status write |
| wp_n | input | 1 | Write-protect pin, low asserts |
| op_done | input | 1 | Pulse when an array or status operation completes |
| permit | output | 1 | One-cycle grant pulse |
| reject | output | 1 | One-cycle refusal pulse |
| wel | output | 1 | Write-enable latch |
| bp | output | 3 | Protect code |
| srwd | output | 1 | Status-lock bit |

## Verification
The completion strobe `op_done` and an incoming enable-write or disable-write request can both land on the latch in the same cycle. The bench provokes this by raising `op_done` together with an enable-write request, and also together with a read. It then judges `wel` in the following cycle against the rule that a set wins over completion. A reject that falls in the same cycle as a completion is also covered: the checker only requires `wel` to hold when no `op_done` preceded it.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;
  typedef enum logic [2:0] {
    OP_WREN = 3'd0,
    OP_WRDI = 3'd1,
    OP_PP   = 3'd2,
    OP_SE   = 3'd3,
    OP_BE   = 3'd4,
    OP_WRSR = 3'd5,
    OP_READ = 3'd6,
    OP_IDLE = 3'd7
  } wp_op_e;

  localparam int BP_W = 3;
endpackage

// File: rtl/wp_region_decode.sv
// Maps the protect code to the lowest sector index that is read-only.
// A result equal to NUM_SEC means nothing is protected.
module wp_region_decode #(
  parameter int SEC_W = 4
) (
  input  logic [2:0]     bp,
  output logic [SEC_W:0] lo_sec
);
  localparam int NUM_SEC = 1 << SEC_W;

  logic [SEC_W:0] tbl [8];

  genvar g;
  generate
    for (g = 0; g < 8; g++) begin : g_code
      if (g == 0) begin : g_none
        assign tbl[g] = (SEC_W + 1)'(NUM_SEC);
      end else if (g <= 4) begin : g_frac
        // code g protects the top NUM_SEC >> (5 - g) sectors
        assign tbl[g] = (SEC_W + 1)'(NUM_SEC - (NUM_SEC >> (5 - g)));
      end else begin : g_all
        assign tbl[g] = '0;
      end
    end
  endgenerate

  assign lo_sec = tbl[bp];
endmodule

// File: rtl/wp_gate.sv
// Decides permit/reject for one request and registers the answer pulses.
module wp_gate
  import flash_wp_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int SEC_W  = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  wp_op_e            op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  clks,
  input  logic              wp_n,
  input  logic              wel,
  input  logic [BP_W-1:0]   bp,
  input  logic              srwd,
  input  logic [SEC_W:0]    lo_sec,
  output logic              grant,
  output logic              permit,
  output logic              reject
);
  logic [SEC_W-1:0] sector;
  logic             is_mod;
  logic             cnt_ok;
  logic             in_region;
  logic             blocked;
  logic             deny;

  assign sector    = addr[ADDR_W-1 -: SEC_W];
  assign in_region = {1'b0, sector} >= lo_sec;
  assign cnt_ok    = (clks != '0) && (clks[2:0] == 3'd0);

  always_comb begin
    is_mod  = 1'b0;
    blocked = 1'b0;
    unique case (op)
      OP_PP, OP_SE: begin
        is_mod  = 1'b1;
        blocked = in_region;
      end
      OP_BE: begin
        is_mod  = 1'b1;
        blocked = (bp != '0);
      end
      OP_WRSR: begin
        is_mod  = 1'b1;
        blocked = srwd && !wp_n;
      end
      default: begin
        is_mod  = 1'b0;
        blocked = 1'b0;
      end
    endcase
  end

  assign grant = cmd_valid && is_mod && wel && cnt_ok && !blocked;
  assign deny  = cmd_valid && is_mod && !grant;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      permit <= 1'b0;
      reject <= 1'b0;
    end else begin
      permit <= grant;
      reject <= deny;
    end
  end
endmodule

// File: rtl/wp_status_regs.sv
// Write-enable latch, protect code and status-lock bit.
module wp_status_regs
  import flash_wp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  wp_op_e          op,
  input  logic [7:0]      data,
  input  logic            grant,
  input  logic            op_done,
  output logic            wel,
  output logic [BP_W-1:0] bp,
  output logic            srwd
);
  logic set_wel;
  logic clr_wel;

  assign set_wel = cmd_valid && (op == OP_WREN);
  assign clr_wel = (cmd_valid && (op == OP_WRDI)) || op_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wel  <= 1'b0;
      bp   <= '0;
      srwd <= 1'b0;
    end else begin
      if (set_wel)      wel <= 1'b1;
      else if (clr_wel) wel <= 1'b0;
      if (grant && (op == OP_WRSR)) begin
        bp   <= data[4:2];
        srwd <= data[7];
      end
    end
  end
endmodule

// File: rtl/flash_wprot_unit.sv
module flash_wprot_unit
  import flash_wp_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int SEC_W  = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [CNT_W-1:0]  cmd_clks,
  input  logic [7:0]        cmd_data,
  input  logic              wp_n,
  input  logic              op_done,
  output logic              permit,
  output logic              reject,
  output logic              wel,
  output logic [2:0]        bp,
  output logic              srwd
);
  wp_op_e         op;
  logic [SEC_W:0] lo_sec;
  logic           grant;

  assign op = wp_op_e'(cmd_op);

  wp_region_decode #(.SEC_W(SEC_W)) u_region (
    .bp     (bp),
    .lo_sec (lo_sec)
  );

  wp_gate #(.ADDR_W(ADDR_W), .SEC_W(SEC_W), .CNT_W(CNT_W)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .op        (op),
    .addr      (cmd_addr),
    .clks      (cmd_clks),
    .wp_n      (wp_n),
    .wel       (wel),
    .bp        (bp),
    .srwd      (srwd),
    .lo_sec    (lo_sec),
    .grant     (grant),
    .permit    (permit),
    .reject    (reject)
  );

  wp_status_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .op        (op),
    .data      (cmd_data),
    .grant     (grant),
    .op_done   (op_done),
    .wel       (wel),
    .bp        (bp),
    .srwd      (srwd)
  );
endmodule

// File: rtl/wp_checker.sv
module wp_checker #(
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [2:0]        cmd_op,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [CNT_W-1:0]  cmd_clks,
  input logic [7:0]        cmd_data,
  input logic              wp_n,
  input logic              op_done,
  input logic              permit,
  input logic              reject,
  input logic              wel,
  input logic [2:0]        bp,
  input logic              srwd
);
  logic mod_req;
  assign mod_req = cmd_valid && (cmd_op inside {3'd2, 3'd3, 3'd4, 3'd5});

  a_r1_wren_sets: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 3'd0 |=> wel);

  a_r2_wrdi_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 3'd1 |=> !wel);

  a_r3_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
    mod_req && !wel |=> reject && !permit);

  a_r5_bulk_locked: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 3'd4 && bp != 3'd0 |=> reject);

  a_r6_hw_lock: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 3'd5 && srwd && !wp_n |=> reject);

  a_r7_byte_count: assert property (@(posedge clk) disable iff (!rst_n)
    mod_req && cmd_clks[2:0] != 3'd0 |=> reject);

  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(permit && reject));

  a_r8_reject_keeps_wel: assert property (@(posedge clk) disable iff (!rst_n)
    reject && !$past(op_done) |-> $stable(wel));

  a_r9_status_only_on_permit: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bp) || !$stable(srwd) |-> permit);

  a_r10_no_answer: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !mod_req |=> !permit && !reject);
endmodule

bind flash_wprot_unit wp_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_wp_checker (.*);

// File: tb/test_flash_wprot_unit.sv
module test_flash_wprot_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [2:0]  cmd_op;
  logic [19:0] cmd_addr;
  logic [15:0] cmd_clks;
  logic [7:0]  cmd_data;
  logic        wp_n;
  logic        op_done;
  logic        permit, reject, wel, srwd;
  logic [2:0]  bp;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  flash_wprot_unit i_flash_wprot_unit (.*);

  // vector: op, addr, clks, data, wp_n, done | exp permit, reject, wel, bp, srwd
  function automatic logic [55:0] V(input logic [2:0] op, input logic [19:0] a,
      input logic [15:0] c, input logic [7:0] d, input logic w, input logic dn,
      input logic ep, input logic er, input logic ew, input logic [2:0] eb,
      input logic es);
    return {op, a, c, d, w, dn, ep, er, ew, eb, es};
  endfunction

  localparam int NV = 30;
  localparam logic [55:0] VEC [NV] = '{
    V(3'd2, 20'h00000, 16'd40, 8'h00, 1, 0, 0, 1, 0, 3'd0, 0), // R3 no latch
    V(3'd0, 20'h00000, 16'd8,  8'h00, 1, 0, 0, 0, 1, 3'd0, 0), // R1 R10 enable
    V(3'd2, 20'h00000, 16'd41, 8'h00, 1, 0, 0, 1, 1, 3'd0, 0), // R7 odd count
    V(3'd2, 20'h00000, 16'd0,  8'h00, 1, 0, 0, 1, 1, 3'd0, 0), // R7 zero count
    V(3'd2, 20'h00000, 16'd40, 8'h00, 1, 0, 1, 0, 1, 3'd0, 0), // R8 permit
    V(3'd6, 20'h00000, 16'd40, 8'h00, 1, 1, 0, 0, 0, 3'd0, 0), // R2 done clears
    V(3'd0, 20'h00000, 16'd8,  8'h00, 1, 0, 0, 0, 1, 3'd0, 0), // R1
    V(3'd5, 20'h00000, 16'd16, 8'h04, 1, 0, 1, 0, 1, 3'd1, 0), // R9 bp=1
    V(3'd3, 20'hF0000, 16'd32, 8'h00, 1, 0, 0, 1, 1, 3'd1, 0), // R4 top sector
    V(3'd3, 20'hEFFFF, 16'd32, 8'h00, 1, 0, 1, 0, 1, 3'd1, 0), // R4 below
    V(3'd5, 20'h00000, 16'd16, 8'h90, 1, 0, 1, 0, 1, 3'd4, 1), // R9 bp=4 lock
    V(3'd2, 20'h80000, 16'd40, 8'h00, 1, 0, 0, 1, 1, 3'd4, 1), // R4 upper half
    V(3'd2, 20'h7FFFF, 16'd40, 8'h00, 1, 0, 1, 0, 1, 3'd4, 1), // R4 lower half
    V(3'd4, 20'h00000, 16'd8,  8'h00, 1, 0, 0, 1, 1, 3'd4, 1), // R5 bulk
    V(3'd5, 20'h00000, 16'd16, 8'h00, 0, 0, 0, 1, 1, 3'd4, 1), // R6 pin low
    V(3'd5, 20'h00000, 16'd16, 8'h00, 1, 0, 1, 0, 1, 3'd0, 0), // R6 pin high
    V(3'd4, 20'h00000, 16'd8,  8'h00, 1, 0, 1, 0, 1, 3'd0, 0), // R5 bulk ok
    V(3'd1, 20'h00000, 16'd8,  8'h00, 1, 0, 0, 0, 0, 3'd0, 0), // R2 disable
    V(3'd0, 20'h00000, 16'd8,  8'h00, 1, 1, 0, 0, 1, 3'd0, 0), // R2 set wins
    V(3'd7, 20'hFFFFF, 16'd8,  8'h9C, 1, 0, 0, 0, 1, 3'd0, 0), // R10 idle
    V(3'd5, 20'h00000, 16'd16, 8'h1C, 0, 0, 1, 0, 1, 3'd7, 0), // R6 srwd=0 R9
    V(3'd2, 20'h00000, 16'd40, 8'h00, 1, 0, 0, 1, 1, 3'd7, 0), // R4 code 7
    V(3'd5, 20'h00000, 16'd16, 8'h18, 1, 0, 1, 0, 1, 3'd6, 0), // R9 bp=6
    V(3'd3, 20'h00000, 16'd32, 8'h00, 1, 0, 0, 1, 1, 3'd6, 0), // R4 code 6
    V(3'd5, 20'h00000, 16'd16, 8'h0C, 1, 0, 1, 0, 1, 3'd3, 0), // R9 bp=3
    V(3'd3, 20'hC0000, 16'd32, 8'h00, 1, 0, 0, 1, 1, 3'd3, 0), // R4 code 3
    V(3'd3, 20'hB0000, 16'd32, 8'h00, 1, 0, 1, 0, 1, 3'd3, 0), // R4 code 3 ok
    V(3'd5, 20'h00000, 16'd16, 8'h08, 1, 0, 1, 0, 1, 3'd2, 0), // R9 bp=2
    V(3'd3, 20'hE0000, 16'd32, 8'h00, 1, 0, 0, 1, 1, 3'd2, 0), // R4 code 2
    V(3'd3, 20'hD0000, 16'd32, 8'h00, 1, 0, 1, 0, 1, 3'd2, 0)  // R4 code 2 ok
  };

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [55:0] v);
    @(negedge clk);
    {cmd_op, cmd_addr, cmd_clks, cmd_data, wp_n, op_done} = v[55:7];
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    op_done   = 1'b0;
  endtask

  task automatic check_vec(input int i, input logic [55:0] v);
    string tag;
    tag = $sformatf("vector %0d", i);
    check(tag, "permit", {7'd0, permit}, {7'd0, v[6]});
    check(tag, "reject", {7'd0, reject}, {7'd0, v[5]});
    check(tag, "wel",    {7'd0, wel},    {7'd0, v[4]});
    check(tag, "bp",     {5'd0, bp},     {5'd0, v[3:1]});
    check(tag, "srwd",   {7'd0, srwd},   {7'd0, v[0]});
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 3'd7; cmd_addr = '0;
    cmd_clks = '0; cmd_data = '0; wp_n = 1'b1; op_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "reset wel",    {7'd0, wel},    8'd0);
    check("R1", "reset bp",     {5'd0, bp},     8'd0);
    check("R1", "reset srwd",   {7'd0, srwd},   8'd0);
    check("R1", "reset permit", {7'd0, permit}, 8'd0);
    check("R1", "reset reject", {7'd0, reject}, 8'd0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      check_vec(i, VEC[i]);
    end

    // R8 pulse lasts one cycle: last vector permitted, now low
    @(negedge clk);
    check("R8", "permit width", {7'd0, permit}, 8'd0);

    // R8 rejected status write keeps latch and status (bp=2 covers E0000h up)
    apply(V(3'd5, 20'h0, 16'd15, 8'h9C, 1, 0, 0, 0, 0, 3'd0, 0));
    check("R8", "reject pulse", {7'd0, reject}, 8'd1);
    check("R8", "bp kept",      {5'd0, bp},     8'd2);
    check("R8", "wel kept",     {7'd0, wel},    8'd1);
    @(negedge clk);
    check("R8", "reject width", {7'd0, reject}, 8'd0);

    // R10 read into protected region is silent and changes nothing
    apply(V(3'd6, 20'hFFFFF, 16'd40, 8'h9C, 0, 0, 0, 0, 0, 3'd0, 0));
    check("R10", "read permit", {7'd0, permit}, 8'd0);
    check("R10", "read reject", {7'd0, reject}, 8'd0);
    check("R10", "read bp",     {5'd0, bp},     8'd2);

    // R1 reset mid-run clears everything
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1", "re-reset wel", {7'd0, wel}, 8'd0);
    check("R1", "re-reset bp",  {5'd0, bp},  8'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule